// File: doc/BRIEF.md
# Dual Divider Bank Clock Crosspoint

This block turns two incoming clocks, a reference clock and the clock from a PLL, into six output clocks. Two divider banks each pick one of the two incoming clocks and derive three divided clocks from it. Bank A provides a programmable divide-by-N, a divide-by-2 and a divide-by-3. Bank B provides a programmable divide-by-N, a divide-by-2 and a divide-by-4. Each of the six outputs then selects one of seven sources (the reference, or one of the six divided clocks) through a 3-bit code, and each output has its own enable.

The design runs on a single fast core clock. Both incoming clocks are sampled as levels, and each bank advances on the rising edges of its selected clock, so every output is a registered waveform on the core clock. All divided clocks in a bank come from one shared counter that restarts on its terminal count, so the fixed taps line up with the divide-by-N tap whenever the divisor allows it. Configuration is written through a simple byte-wide register write port. A new divisor waits for the end of the current divide period, and a new source choice waits until both the old and the new source are low, so no output ever produces a runt pulse.

Top module: `clkxb_top`

## Requirements
- R1: After reset every output enable and every output value is 0, both banks use divisor 4 from the reference, and every output selects code 000.
- R2: A write to 0x0C configures bank A and a write to 0x47 configures bank B: bit 7 selects the bank's clock (1 = PLL clock, 0 = reference clock) and bits 6:0 hold the divisor N. An N below 4 behaves as N = 4.
- R3: The divide-by-N tap of a bank has a period of N cycles of its selected clock and stays high for floor(N/2) of them.
- R4: With an even N, each bank's divide-by-2 tap has a period of 2 selected-clock cycles and is high for 1. With N a multiple of 3, bank A's divide-by-3 tap has a period of 3 and is high for 1. With N a multiple of 4, bank B's divide-by-4 tap has a period of 4 and is high for 2.
- R5: Every rising edge of a bank's divide-by-N tap coincides with a rising edge of its divide-by-2 tap when N is a multiple of 4, with bank A's divide-by-3 tap when N is 6, and with bank B's divide-by-4 tap when N is a multiple of 8.
- R6: Output source codes are 000 reference, 001 bank A /N, 010 bank A /2, 011 bank A /3, 100 bank B /N, 101 bank B /2, 110 bank B /4. The six 3-bit codes for outputs 1 to 6 are packed most significant bit first as one 18-bit field made of 0x44 bits 7:0, 0x45 bits 7:0 and 0x46 bits 7:6 in that order.
- R7: Source code 111 holds the output low.
- R8: Bit k-1 of register 0x09 enables output k; a disabled output drives its enable low and its value low.
- R9: A divisor written mid-period takes effect only after the current period ends at the terminal count; the period in progress completes with the old N.
- R10: A source change on an output happens only in a cycle where both the old and the new source are low, so every high pulse on the output is a complete high phase of one of the two sources.
- R11: Writes to any address other than 0x09, 0x0C and 0x44 to 0x47 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than both incoming clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, sampled as a level |
| pll_clk_i | input | 1 | PLL clock, sampled as a level |
| cfg_we | input | 1 | Register write strobe, one cycle per byte |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| clk_out | output | 6 | Output clock values, bit k-1 is output k |
| clk_oe | output | 6 | Output drive enables, low means the pad floats |

## Verification
On every cycle the assertions check that each bank counter stays below its divisor, that a divisor only changes at a terminal count, that the fixed taps rise together with the divide-by-N tap under the divisibility conditions, that a disabled or reserved-code output stays low, that a source switch happens only while the output is low, and that writes to unmapped addresses leave the registers alone. Only the bench scenarios show the actual periods and high times at the ports for a sweep of divisors on both clock choices, the packing of the source codes across three registers, the behaviour of a divisor written mid-period, and the shape of the output waveform around a source switch.

// File: rtl/clkxb_pkg.sv
// Package: shared constants and source codes for the dual divider bank crosspoint.
// Assumes a fixed register map of six outputs with 3-bit source codes.
package clkxb_pkg;
    localparam int NOUT    = 6;     // number of output clocks
    localparam int SELW    = 3;     // width of one source code
    localparam int NW      = 7;     // divisor field width
    localparam int NMIN    = 4;     // smallest divisor honoured
    localparam int XBW     = NOUT * SELW;
    localparam int NSRC    = 1 << SELW;

    localparam logic [7:0] ADDR_OE  = 8'h09;
    localparam logic [7:0] ADDR_BKA = 8'h0C;
    localparam logic [7:0] ADDR_XB0 = 8'h44;
    localparam logic [7:0] ADDR_XB1 = 8'h45;
    localparam logic [7:0] ADDR_XB2 = 8'h46;
    localparam logic [7:0] ADDR_BKB = 8'h47;

    typedef enum logic [SELW-1:0] {
        SRC_REF  = 3'd0,
        SRC_AN   = 3'd1,
        SRC_A2   = 3'd2,
        SRC_A3   = 3'd3,
        SRC_BN   = 3'd4,
        SRC_B2   = 3'd5,
        SRC_B4   = 3'd6,
        SRC_OFF  = 3'd7
    } src_code_e;
endpackage

// File: rtl/clkxb_regs.sv
// Module: configuration register file of the crosspoint.
// Holds the enable byte, both bank bytes and the packed 18-bit source field.
// Assumes one byte written per strobe; unmapped addresses are dropped.
module clkxb_regs
    import clkxb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [NOUT-1:0] oe_cfg,
    output logic [7:0]      bka_cfg,
    output logic [7:0]      bkb_cfg,
    output logic [XBW-1:0]  xb_flat
);
    localparam int TAILW = XBW - 16;

    logic [NOUT-1:0]  oe_q;
    logic [7:0]       bka_q;
    logic [7:0]       bkb_q;
    logic [7:0]       xb0_q;
    logic [7:0]       xb1_q;
    logic [TAILW-1:0] xb2_q;
    logic             hit;

    // Decode whether the write address belongs to this block.
    always_comb begin
        hit = (addr == ADDR_OE) || (addr == ADDR_BKA) || (addr == ADDR_BKB) ||
              (addr == ADDR_XB0) || (addr == ADDR_XB1) || (addr == ADDR_XB2);
    end

    // Capture written bytes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= '0;
            bka_q <= '0;
            bkb_q <= '0;
            xb0_q <= '0;
            xb1_q <= '0;
            xb2_q <= '0;
        end else if (we) begin
            case (addr)
                ADDR_OE:  oe_q  <= wdata[NOUT-1:0];
                ADDR_BKA: bka_q <= wdata;
                ADDR_BKB: bkb_q <= wdata;
                ADDR_XB0: xb0_q <= wdata;
                ADDR_XB1: xb1_q <= wdata;
                ADDR_XB2: xb2_q <= wdata[7 -: TAILW];
                default:  ;
            endcase
        end
    end

    assign oe_cfg  = oe_q;
    assign bka_cfg = bka_q;
    assign bkb_cfg = bkb_q;
    assign xb_flat = {xb0_q, xb1_q, xb2_q};

    assert_unmapped_ignored_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> ($stable(oe_q) && $stable(bka_q) && $stable(bkb_q) &&
                          $stable(xb0_q) && $stable(xb1_q) && $stable(xb2_q)));
endmodule

// File: rtl/clkxb_bank.sv
// Module: one divider bank.
// Picks the PLL or reference tick, runs one counter modulo N and derives the
// divide-by-N, divide-by-2 and a third fixed tap (/3 or /4 by THIRD_DIV) from it.
// Assumes ticks are single-cycle pulses on the core clock. A new N is loaded
// only at the terminal count; N below NMIN is raised to NMIN.
module clkxb_bank
    import clkxb_pkg::*;
#(
    parameter int THIRD_DIV = 3,
    parameter int DW        = NW,
    parameter int DMIN      = NMIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          pll_tick,
    input  logic [7:0]    cfg,
    output logic          tap_n,
    output logic          tap_2,
    output logic          tap_x
);
    localparam logic [DW-1:0] N_FLOOR = DW'(DMIN);

    logic          use_pll;
    logic [DW-1:0] n_req;
    logic [DW-1:0] n_eff;
    logic [DW-1:0] n_act;
    logic [DW-1:0] cnt;
    logic          tick;
    logic          term;

    assign use_pll = cfg[7];
    assign n_req   = cfg[DW-1:0];

    // Clamp the requested divisor and pick the advancing tick.
    always_comb begin
        n_eff = (n_req < N_FLOOR) ? N_FLOOR : n_req;
        tick  = use_pll ? pll_tick : ref_tick;
        term  = (cnt == n_act - DW'(1));
    end

    // Shared counter; reloads the divisor only at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            n_act <= N_FLOOR;
        end else if (tick) begin
            if (term) begin
                cnt   <= '0;
                n_act <= n_eff;
            end else begin
                cnt   <= cnt + DW'(1);
            end
        end
    end

    // Divide-by-N is high for the first floor(N/2) counts; /2 on even counts.
    always_comb begin
        tap_n = (cnt < (n_act >> 1));
        tap_2 = ~cnt[0];
    end

    generate
        if (THIRD_DIV == 3) begin : g_div3
            logic [1:0] c3;
            // Modulo-3 phase counter restarted with the shared counter.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c3 <= '0;
                end else if (tick) begin
                    if (term || c3 == 2'd2) c3 <= '0;
                    else                    c3 <= c3 + 2'd1;
                end
            end
            assign tap_x = (c3 == 2'd0);

            assert_align3_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(tap_n) && $stable(n_act) && n_act == DW'(6)) |-> $rose(tap_x));
        end else begin : g_div4
            // Divide-by-4 taken from the two low counter bits.
            assign tap_x = ~cnt[1];

            assert_align4_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(tap_n) && $stable(n_act) && n_act[2:0] == 3'd0) |-> $rose(tap_x));
        end
    endgenerate

    assert_cnt_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt < n_act);
    assert_n_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && term) |=> $stable(n_act));
    assert_align2_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tap_n) && $stable(n_act) && n_act[1:0] == 2'd0) |-> $rose(tap_2));
endmodule

// File: rtl/clkxb_outmux.sv
// Module: one output of the crosspoint.
// Selects one of the eight source lines by a 3-bit code and registers the value.
// A new code is adopted only in a cycle where old and new sources are both low.
// Assumes source line 7 is tied low by the parent.
module clkxb_outmux
    import clkxb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_vec,
    input  logic [SELW-1:0] sel_cfg,
    input  logic            oe_cfg,
    output logic            out_val,
    output logic            out_oe
);
    logic [SELW-1:0] sel_act;
    logic            safe_swap;

    // Swap is safe when both the active and the requested source are low.
    always_comb begin
        safe_swap = (sel_cfg != sel_act) && !src_vec[sel_act] && !src_vec[sel_cfg];
    end

    // Track the active source code.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_act <= SRC_REF;
        else if (safe_swap) sel_act <= sel_cfg;
    end

    // Register the gated output value and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val <= 1'b0;
            out_oe  <= 1'b0;
        end else begin
            out_val <= oe_cfg & src_vec[sel_act];
            out_oe  <= oe_cfg;
        end
    end

    assert_reserved_low_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act == SRC_OFF) |=> !out_val);
    assert_disabled_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !oe_cfg |=> (!out_val && !out_oe));
    assert_switch_low_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_act) |-> !out_val);
endmodule

// File: rtl/clkxb_top.sv
// Module: dual divider bank clock crosspoint, top level.
// Samples both incoming clocks on the core clock, feeds two divider banks,
// and routes seven sources to six gated outputs.
// Assumes the core clock is at least twice as fast as either incoming clock.
module clkxb_top
    import clkxb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_clk_i,
    input  logic            pll_clk_i,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [NOUT-1:0] clk_out,
    output logic [NOUT-1:0] clk_oe
);
    logic            ref_q, ref_d, pll_q, pll_d;
    logic            ref_tick, pll_tick;
    logic [NOUT-1:0] oe_cfg;
    logic [7:0]      bka_cfg, bkb_cfg;
    logic [XBW-1:0]  xb_flat;
    logic            a_n, a_2, a_3, b_n, b_2, b_4;
    logic [NSRC-1:0] src_vec;

    // Sample incoming clock levels and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            ref_d <= 1'b0;
            pll_q <= 1'b0;
            pll_d <= 1'b0;
        end else begin
            ref_q <= ref_clk_i;
            ref_d <= ref_q;
            pll_q <= pll_clk_i;
            pll_d <= pll_q;
        end
    end

    assign ref_tick = ref_q & ~ref_d;
    assign pll_tick = pll_q & ~pll_d;

    clkxb_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .oe_cfg  (oe_cfg),
        .bka_cfg (bka_cfg),
        .bkb_cfg (bkb_cfg),
        .xb_flat (xb_flat)
    );

    clkxb_bank #(.THIRD_DIV(3)) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .pll_tick (pll_tick),
        .cfg      (bka_cfg),
        .tap_n    (a_n),
        .tap_2    (a_2),
        .tap_x    (a_3)
    );

    clkxb_bank #(.THIRD_DIV(4)) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .pll_tick (pll_tick),
        .cfg      (bkb_cfg),
        .tap_n    (b_n),
        .tap_2    (b_2),
        .tap_x    (b_4)
    );

    // Source lines indexed by source code; code 7 is tied low.
    assign src_vec = {1'b0, b_4, b_2, b_n, a_3, a_2, a_n, ref_q};

    generate
        for (genvar k = 0; k < NOUT; k++) begin : g_out
            clkxb_outmux u_mux (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_vec (src_vec),
                .sel_cfg (xb_flat[XBW-1-SELW*k -: SELW]),
                .oe_cfg  (oe_cfg[k]),
                .out_val (clk_out[k]),
                .out_oe  (clk_oe[k])
            );
        end
    endgenerate
endmodule

// File: tb/tb_clkxb_top.sv
`timescale 1ns/1ps
module tb_clkxb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic       pll_clk = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] clk_out;
    logic [5:0] clk_oe;

    int n_chk = 0;
    int n_bad = 0;
    localparam int PLL_P = 2;   // PLL clock period in core cycles
    localparam int REF_P = 6;   // reference clock period in core cycles

    always #2.5 clk = ~clk;

    clkxb_top dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .pll_clk_i(pll_clk),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    initial forever begin @(negedge clk); pll_clk = ~pll_clk; end
    initial forever begin repeat (REF_P/2) @(negedge clk); ref_clk = ~ref_clk; end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge: drives one byte write for one posedge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Packs codes for outputs 1..6 MSB-first into 0x44, 0x45, 0x46[7:6] (R6).
    task automatic set_codes(input logic [2:0] c1, c2, c3, c4, c5, c6);
        logic [17:0] v;
        v = {c1, c2, c3, c4, c5, c6};
        wr(8'h44, v[17:10]);
        wr(8'h45, v[9:2]);
        wr(8'h46, {v[1:0], 6'b000000});
    endtask

    task automatic wait_rise(input int k);
        logic prev, cur;
        prev = clk_out[k];
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            cur = clk_out[k];
            if (!prev && cur) return;
            prev = cur;
        end
    endtask

    // From a sample where output k is high after a rise: cycles to next rise.
    task automatic next_rise(input int k, output int per, output int hi);
        logic prev, cur;
        per = 0; hi = 1; prev = 1'b1;
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            per++;
            cur = clk_out[k];
            if (!prev && cur) return;
            if (cur) hi++;
            prev = cur;
        end
    endtask

    task automatic check_wave(input int k, input int eper, input int ehi, input string req);
        int per, hi;
        wait_rise(k);
        next_rise(k, per, hi);
        check(per == eper, req, per, eper);
        check(hi == ehi, req, hi, ehi);
    endtask

    task automatic align(input int a, input int b, input int win, input string req);
        logic pa, pb, ca, cb;
        int ra, both;
        ra = 0; both = 0; pa = clk_out[a]; pb = clk_out[b];
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            ca = clk_out[a]; cb = clk_out[b];
            if (!pa && ca) begin
                ra++;
                if (!pb && cb) both++;
            end
            pa = ca; pb = cb;
        end
        check(ra > 0 && both == ra, req, both, ra);
    endtask

    initial begin
        int per, hi, hi_a, hi_b, run, pulses, bad, longp;
        int n1s[8] = '{4, 6, 8, 12, 5, 24, 7, 16};
        int n2s[8] = '{4, 8, 12, 16, 9, 32, 5, 8};
        logic [5:0] seen;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1: all quiet after reset
        check(clk_oe == 6'h00, "R1 oe", clk_oe, 0);
        check(clk_out == 6'h00, "R1 out", clk_out, 0);

        wr(8'h09, 8'h3F);
        set_codes(3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6);

        // R3 R4 R5: sweep of divisors, bank A on PLL, bank B on reference
        foreach (n1s[i]) begin
            int n1, n2, win;
            n1 = n1s[i]; n2 = n2s[i];
            wr(8'h0C, 8'h80 | 8'(n1));
            wr(8'h47, 8'(n2));
            repeat (2 * (PLL_P * n1 + REF_P * n2) + 600) @(negedge clk);
            check_wave(0, PLL_P * n1, PLL_P * (n1 / 2), "R3 bankA /N");
            check_wave(3, REF_P * n2, REF_P * (n2 / 2), "R3 bankB /N");
            if (n1 % 2 == 0) check_wave(1, 2 * PLL_P, PLL_P, "R4 bankA /2");
            if (n1 % 3 == 0) check_wave(2, 3 * PLL_P, PLL_P, "R4 bankA /3");
            if (n2 % 2 == 0) check_wave(4, 2 * REF_P, REF_P, "R4 bankB /2");
            if (n2 % 4 == 0) check_wave(5, 4 * REF_P, 2 * REF_P, "R4 bankB /4");
            win = 3 * (PLL_P * n1 + REF_P * n2);
            if (n1 % 4 == 0) align(0, 1, win, "R5 A /2 align");
            if (n1 == 6)     align(0, 2, win, "R5 A /3 align");
            if (n2 % 4 == 0) align(3, 4, win, "R5 B /2 align");
            if (n2 % 8 == 0) align(3, 5, win, "R5 B /4 align");
        end

        // R2: clock choice and divisor clamp
        wr(8'h0C, 8'h81);
        repeat (800) @(negedge clk);
        check_wave(0, PLL_P * 4, PLL_P * 2, "R2 clamp N=1");
        wr(8'h0C, 8'h05);
        repeat (800) @(negedge clk);
        check_wave(0, REF_P * 5, REF_P * 2, "R2 ref select");

        // R6: reversed code order exercises the packing across registers
        wr(8'h0C, 8'h80 | 8'd12);
        wr(8'h47, 8'd8);
        set_codes(3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1);
        repeat (1200) @(negedge clk);
        check_wave(0, 4 * REF_P, 2 * REF_P, "R6 out1 code 110");
        check_wave(1, 2 * REF_P, REF_P, "R6 out2 code 101");
        check_wave(2, 8 * REF_P, 4 * REF_P, "R6 out3 code 100");
        check_wave(3, 3 * PLL_P, PLL_P, "R6 out4 code 011");
        check_wave(4, 2 * PLL_P, PLL_P, "R6 out5 code 010");
        check_wave(5, 12 * PLL_P, 6 * PLL_P, "R6 out6 code 001");
        set_codes(3'd0, 3'd7, 3'd4, 3'd3, 3'd2, 3'd1);
        repeat (400) @(negedge clk);
        check_wave(0, REF_P, REF_P / 2, "R6 out1 code 000");

        // R7: reserved code holds output 2 low while enabled
        seen = '0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (clk_out[1]) seen[1] = 1'b1;
        end
        check(seen[1] == 1'b0, "R7 code 111 low", seen[1], 0);
        check(clk_oe[1] == 1'b1, "R7 oe kept", clk_oe[1], 1);

        // R8: enable mask 0x15 enables outputs 1, 3, 5
        set_codes(3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1);
        wr(8'h09, 8'h15);
        repeat (400) @(negedge clk);
        check(clk_oe == 6'h15, "R8 oe mask", clk_oe, 6'h15);
        seen = '0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            seen = seen | clk_out;
        end
        check(seen == 6'h15, "R8 disabled low", seen, 6'h15);
        wr(8'h09, 8'h3F);

        // R9: divisor change mid-period finishes the old period first
        wr(8'h0C, 8'h80 | 8'd8);
        repeat (600) @(negedge clk);
        wait_rise(0);
        cfg_we = 1'b1; cfg_addr = 8'h0C; cfg_wdata = 8'h80 | 8'd12;
        @(negedge clk);
        cfg_we = 1'b0;
        begin
            logic prev, cur;
            per = 1; prev = clk_out[0];
            for (int g = 0; g < 4000; g++) begin
                @(negedge clk);
                per++;
                cur = clk_out[0];
                if (!prev && cur) break;
                prev = cur;
            end
        end
        check(per == PLL_P * 8, "R9 old period", per, PLL_P * 8);
        next_rise(0, per, hi);
        check(per == PLL_P * 12, "R9 new period", per, PLL_P * 12);

        // R10: switch output 1 from bank A /N (high 8) to bank B /N (high 24)
        wr(8'h0C, 8'h80 | 8'd8);
        wr(8'h47, 8'd8);
        repeat (800) @(negedge clk);
        hi_a = PLL_P * 4; hi_b = REF_P * 4;
        wait_rise(0);
        while (clk_out[0]) @(negedge clk);
        set_codes(3'd4, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1);
        run = 0; pulses = 0; bad = 0; longp = 0;
        begin
            logic prev, cur, inrun;
            prev = clk_out[0]; inrun = 1'b0;
            for (int c = 0; c < 800; c++) begin
                @(negedge clk);
                cur = clk_out[0];
                if (!prev && cur) begin inrun = 1'b1; run = 0; end
                if (inrun && cur) run++;
                if (inrun && prev && !cur) begin
                    pulses++;
                    if (run != hi_a && run != hi_b) bad++;
                    if (run == hi_b) longp++;
                    inrun = 1'b0;
                end
                prev = cur;
            end
        end
        check(bad == 0 && pulses > 0, "R10 no runt", bad, 0);
        check(longp > 0, "R10 switched", longp, 1);

        // R11: unmapped writes change nothing
        set_codes(3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1);
        repeat (200) @(negedge clk);
        wr(8'h00, 8'h00);
        wr(8'h0A, 8'h00);
        wr(8'h43, 8'h00);
        wr(8'h48, 8'h00);
        wr(8'hFF, 8'h00);
        wr(8'h08, 8'h00);
        repeat (100) @(negedge clk);
        check(clk_oe == 6'h3F, "R11 oe kept", clk_oe, 6'h3F);
        check_wave(0, PLL_P * 8, PLL_P * 4, "R11 divisor kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule